// File: doc/BRIEF.md
# Round-Robin TDC Readout Multiplexer

This block gathers time-stamp words from a configurable number of TDC channel sources and merges them into a single outgoing word stream for a serial link. Each channel has its own small FIFO. A scheduler visits the channels in ascending index order and emits exactly one word for each channel. When a channel has nothing queued, it fills that slot with a placeholder word. After the last channel's slot, the scheduler emits a control token, which closes the readout cycle. A downstream receiver can therefore tell which TDC supplied a word from the word's slot position alone.

The outgoing stream is a data word plus a control flag. Downstream logic uses the flag to pick a line-code control character for the token instead of a data character. Flow control is a ready signal from the downstream side. While ready is low, the current output word is held and no slot is lost. Each channel has a sticky overflow flag. It records that a word reached that channel while its FIFO was full.

The scheduler is a two-state machine. State `S_SLOT` carries a slot index and emits one channel word or one placeholder for each accepted output. Transition slot-advance goes from `S_SLOT` to `S_SLOT` with the next index. Transition end-of-cycle goes from `S_SLOT` at the last index to `S_TOKEN`. State `S_TOKEN` emits the delimiter. Transition restart goes from `S_TOKEN` to `S_SLOT` at index 0. Reset enters `S_SLOT` at index 0.

Top module: `tdc_rr_mux`

## Requirements
- R1: While reset is asserted, `link_valid`, `link_ctrl` and every `ovf_flags` bit are 0. The first clock edge after reset is released presents slot 0 with `link_valid` high.
- R2: The output stream repeats a fixed pattern: one word for each channel in ascending index order 0 to NUM_CH-1, then one token. Exactly NUM_CH non-control words lie between two tokens.
- R3: When a channel's FIFO holds words as its slot is loaded, the slot carries the oldest queued word with `link_ctrl` = 0, and that word is removed. At most one word is removed from any channel per readout cycle.
- R4: When a channel's FIFO is empty as its slot is loaded, the slot carries the placeholder word. The placeholder has the reserved header 4'hF in bits [31:28] and zeros in all other bits, with `link_ctrl` = 0.
- R5: The delimiter is the word 32'h0000_00BC with `link_ctrl` = 1. `link_ctrl` is 1 for no other word.
- R6: While `link_valid` is high and `link_ready` is low, `link_word` and `link_ctrl` hold their values, no FIFO word is removed, and the slot index does not advance.
- R7: An input word whose bits [31:28] equal the reserved header 4'hF is discarded. It is not queued and does not set the overflow flag.
- R8: An input word that arrives while its channel's FIFO holds FIFO_DEPTH words is dropped. The word sets that channel's `ovf_flags` bit, and the bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tdc_valid | input | NUM_CH | Per-channel word strobe |
| tdc_word | input | NUM_CH*DATA_W | Per-channel words, channel c at bits [c*DATA_W +: DATA_W] |
| link_ready | input | 1 | Downstream accepts the current word |
| link_valid | output | 1 | Output word is valid |
| link_word | output | DATA_W | Output data word, placeholder or token |
| link_ctrl | output | 1 | Marks the control-token word |
| ovf_flags | output | NUM_CH | Sticky per-channel overflow flags |

## Verification
A word strobed in at edge k lands in its FIFO at that edge. The earliest slot that can carry it is loaded at edge k+1. The output registers change only at an edge where `link_valid` is low or `link_ready` is high, and they show the new word right after that edge. An overflow flag rises at the same edge as the rejected word. The bench drives inputs on the falling edge and advances a cycle model of the requirements on each rising edge. It then compares every output on the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/tdc_rr_pkg.sv
package tdc_rr_pkg;

    // Scheduler states: channel slot or end-of-cycle delimiter
    typedef enum logic [0:0] {
        S_SLOT  = 1'b0,
        S_TOKEN = 1'b1
    } rr_state_e;

endpackage

// File: rtl/tdc_chan_fifo.sv
module tdc_chan_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    assign empty = (count == '0);
    assign full  = (count == CNT_FULL);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);  // R8

endmodule

// File: rtl/tdc_chan_lane.sv
module tdc_chan_lane #(
    parameter int              DATA_W = 32,
    parameter int              DEPTH  = 4,
    parameter int              HDR_W  = 4,
    parameter logic [HDR_W-1:0] RES_HDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              ovf
);
    logic is_reserved;
    logic full;
    logic push;
    logic ovf_q;

    assign is_reserved = (in_data[DATA_W-1 -: HDR_W] == RES_HDR);
    assign push        = in_valid && !is_reserved && !full;
    assign ovf         = ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (in_valid && !is_reserved && full) begin
            ovf_q <= 1'b1;
        end
    end

    tdc_chan_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (in_data),
        .pop   (pop),
        .rdata (head),
        .empty (empty),
        .full  (full)
    );

    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);  // R8

endmodule

// File: rtl/tdc_slot_fsm.sv
module tdc_slot_fsm
    import tdc_rr_pkg::*;
#(
    parameter int                NUM_CH     = 6,
    parameter int                DATA_W     = 32,
    parameter int                HDR_W      = 4,
    parameter logic [HDR_W-1:0]  RES_HDR    = '1,
    parameter logic [DATA_W-1:0] TOKEN_CODE = 'hBC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*DATA_W-1:0] heads,
    input  logic [NUM_CH-1:0]        empty,
    input  logic                     out_ready,
    output logic [NUM_CH-1:0]        pop,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_ctrl
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST    = IDX_W'(NUM_CH - 1);
    localparam logic [DATA_W-1:0] PLACEHOLDER = {RES_HDR, {(DATA_W-HDR_W){1'b0}}};

    rr_state_e         state_q, state_d;
    logic [IDX_W-1:0]  slot_q, slot_d;
    logic              load;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q, data_d;
    logic              out_ctrl_q, ctrl_d;

    assign load      = !out_valid_q || out_ready;
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign out_ctrl  = out_ctrl_q;

    // Next state, next word and pop selection
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        data_d  = out_data_q;
        ctrl_d  = out_ctrl_q;
        pop     = '0;
        if (load) begin
            unique case (state_q)
                S_SLOT: begin
                    ctrl_d = 1'b0;
                    if (!empty[slot_q]) begin
                        data_d      = heads[slot_q*DATA_W +: DATA_W];
                        pop[slot_q] = 1'b1;
                    end else begin
                        data_d = PLACEHOLDER;
                    end
                    if (slot_q == IDX_LAST) begin
                        state_d = S_TOKEN;
                        slot_d  = '0;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
                S_TOKEN: begin
                    data_d  = TOKEN_CODE;
                    ctrl_d  = 1'b1;
                    state_d = S_SLOT;
                    slot_d  = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SLOT;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            out_ctrl_q  <= 1'b0;
        end else if (load) begin
            out_valid_q <= 1'b1;
            out_data_q  <= data_d;
            out_ctrl_q  <= ctrl_d;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_data_q) && $stable(out_ctrl_q)));  // R6
    AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && !out_ready) |-> (pop == '0));  // R6
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= IDX_LAST);  // R2
    AST_TOKEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && state_q == S_TOKEN) |=> (out_valid_q && out_ctrl_q));  // R5

endmodule

// File: rtl/tdc_rr_mux.sv
module tdc_rr_mux #(
    parameter int                NUM_CH     = 6,
    parameter int                DATA_W     = 32,
    parameter int                FIFO_DEPTH = 4,
    parameter int                HDR_W      = 4,
    parameter logic [HDR_W-1:0]  RES_HDR    = 4'hF,
    parameter logic [DATA_W-1:0] TOKEN_CODE = 32'h0000_00BC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        tdc_valid,
    input  logic [NUM_CH*DATA_W-1:0] tdc_word,
    input  logic                     link_ready,
    output logic                     link_valid,
    output logic [DATA_W-1:0]        link_word,
    output logic                     link_ctrl,
    output logic [NUM_CH-1:0]        ovf_flags
);
    logic [NUM_CH*DATA_W-1:0] heads;
    logic [NUM_CH-1:0]        empty;
    logic [NUM_CH-1:0]        pop;

    initial begin
        assert (NUM_CH >= 1 && NUM_CH <= 18 && DATA_W > HDR_W && FIFO_DEPTH >= 1);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        tdc_chan_lane #(
            .DATA_W  (DATA_W),
            .DEPTH   (FIFO_DEPTH),
            .HDR_W   (HDR_W),
            .RES_HDR (RES_HDR)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (tdc_valid[c]),
            .in_data  (tdc_word[c*DATA_W +: DATA_W]),
            .pop      (pop[c]),
            .head     (heads[c*DATA_W +: DATA_W]),
            .empty    (empty[c]),
            .ovf      (ovf_flags[c])
        );
    end

    tdc_slot_fsm #(
        .NUM_CH     (NUM_CH),
        .DATA_W     (DATA_W),
        .HDR_W      (HDR_W),
        .RES_HDR    (RES_HDR),
        .TOKEN_CODE (TOKEN_CODE)
    ) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .heads     (heads),
        .empty     (empty),
        .out_ready (link_ready),
        .pop       (pop),
        .out_valid (link_valid),
        .out_data  (link_word),
        .out_ctrl  (link_ctrl)
    );

    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));  // R3
    AST_CTRL_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        link_ctrl |-> link_valid);  // R5

endmodule

// File: tb/tdc_rr_mux_tb.sv
module tdc_rr_mux_tb_top;
    localparam int NCH   = 6;
    localparam int DW    = 32;
    localparam int DEPTH = 4;
    localparam logic [DW-1:0] TOKEN = 32'h0000_00BC;
    localparam logic [DW-1:0] PHOLD = 32'hF000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] drv_valid = '0;
    logic [DW-1:0]  drv_data [NCH];
    logic [NCH*DW-1:0] drv_flat;
    logic          drv_ready = 1'b1;
    logic          link_valid, link_ctrl;
    logic [DW-1:0] link_word;
    logic [NCH-1:0] ovf_flags;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // cycle model of the requirements
    logic [DW-1:0] mq [NCH][$];
    logic          m_valid, m_ctrl, m_tok;
    logic [DW-1:0] m_data;
    int            m_idx;
    logic [NCH-1:0] m_ovf;

    always #10 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) drv_flat[c*DW +: DW] = drv_data[c];
    end

    tdc_rr_mux dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdc_valid  (drv_valid),
        .tdc_word   (drv_flat),
        .link_ready (drv_ready),
        .link_valid (link_valid),
        .link_word  (link_word),
        .link_ctrl  (link_ctrl),
        .ovf_flags  (ovf_flags)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) mq[c].delete();
            m_valid = 0; m_ctrl = 0; m_tok = 0; m_data = '0; m_idx = 0; m_ovf = '0;
        end else begin
            int sz [NCH];
            for (int c = 0; c < NCH; c++) sz[c] = mq[c].size();
            if (!m_valid || drv_ready) begin
                m_valid = 1;
                if (m_tok) begin                       // R5 delimiter
                    m_data = TOKEN; m_ctrl = 1; m_tok = 0; m_idx = 0;
                end else begin                         // R2 slot order
                    m_ctrl = 0;
                    if (sz[m_idx] != 0) m_data = mq[m_idx].pop_front();  // R3
                    else m_data = PHOLD;                                  // R4
                    if (m_idx == NCH-1) begin m_tok = 1; m_idx = 0; end
                    else m_idx = m_idx + 1;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (drv_valid[c] && drv_data[c][31:28] != 4'hF) begin   // R7
                    if (sz[c] == DEPTH) m_ovf[c] = 1'b1;                 // R8
                    else mq[c].push_back(drv_data[c]);
                end
            end
        end
    end

    task automatic fail(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        errors++;
        $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    function automatic string data_tag(input logic ctrl, input logic [DW-1:0] d);
        if (ctrl) return "R5";
        if (d == PHOLD) return "R4";
        return "R3";
    endfunction

    task automatic compare();
        checks++;
        if (link_valid !== m_valid || link_ctrl !== m_ctrl)
            fail("R2", "valid/ctrl", {30'd0, link_valid, link_ctrl}, {30'd0, m_valid, m_ctrl});
        else if (m_valid && link_word !== m_data)
            fail(data_tag(m_ctrl, m_data), "word", link_word, m_data);
        else if (ovf_flags !== m_ovf)
            fail("R8", "ovf_flags", DW'(ovf_flags), DW'(m_ovf));
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        drv_valid = '0;
        for (int c = 0; c < NCH; c++) drv_data[c] = '0;
    endtask

    initial begin
        int unsigned seed_v;
        logic [DW-1:0] held;
        seed_v = $urandom(32'd9157);
        quiet();
        drv_ready = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (link_valid !== 0 || link_ctrl !== 0 || ovf_flags !== '0)
            fail("R1", "reset outputs", {link_valid, link_ctrl, 30'(ovf_flags)}, '0);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (link_valid !== 1 || link_word !== PHOLD || link_ctrl !== 0)
            fail("R1", "first slot after reset", link_word, PHOLD);
        compare();
        // R4 and R2: idle cycles, placeholders and tokens only
        repeat (2*(NCH+1)) tick();
        // R3: one word per channel, then observe
        for (int c = 0; c < NCH; c++) begin
            drv_valid[c] = 1; drv_data[c] = {4'(c), 28'(c * 32'h111)};
        end
        tick(); quiet();
        repeat (2*(NCH+1)) tick();
        // R6 stall with words arriving
        drv_ready = 0;
        tick();
        held = link_word;
        drv_valid[0] = 1; drv_data[0] = 32'h1234_5678;
        tick(); quiet();
        repeat (4) tick();
        checks++;
        if (link_word !== held || link_valid !== 1) fail("R6", "held word", link_word, held);
        drv_ready = 1;
        repeat (2*(NCH+1)) tick();
        // R7 reserved header discarded
        drv_valid[2] = 1; drv_data[2] = 32'hF0AB_CDEF;
        tick(); quiet();
        repeat (2*(NCH+1)) tick();
        checks++;
        if (ovf_flags !== '0) fail("R7", "ovf after reserved word", DW'(ovf_flags), '0);
        // R8 overflow on channel 1
        drv_ready = 0;
        for (int k = 0; k < DEPTH + 2; k++) begin
            drv_valid[1] = 1; drv_data[1] = 32'h5000_0000 + k;
            tick();
        end
        quiet();
        tick();
        checks++;
        if (ovf_flags[1] !== 1'b1) fail("R8", "ovf set", DW'(ovf_flags), 32'h2);
        drv_ready = 1;
        repeat (4*(NCH+1)) tick();
        checks++;
        if (ovf_flags[1] !== 1'b1) fail("R8", "ovf sticky", DW'(ovf_flags), 32'h2);
        // random traffic against the model (R2..R8)
        for (int n = 0; n < 4000; n++) begin
            tick();
            drv_ready = ($urandom % 5) != 0;
            for (int c = 0; c < NCH; c++) begin
                drv_valid[c] = ($urandom % 10) == 0;
                drv_data[c]  = $urandom;
            end
        end
        quiet();
        drv_ready = 1;
        repeat (20) tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule